// File: doc/BRIEF.md
# Processor Interrupt Entry and Return Unit

This block sits next to a 32-bit processor core and makes the decisions the core needs when it takes an interrupt or returns from one. Each cycle it looks at seven request inputs: system reset, machine check, instruction-storage fault, data-storage fault, system call, external request and decrementer. It also sees the current machine state word (`msr_in`) and the addresses of the current and next instruction. It picks one winner. It then loads the two save/restore registers, forms the new machine state and sends fetch to the vector of that source. An `rfi_req` strobe does the reverse: the saved state word goes back to the core and fetch resumes at the saved address.

All outputs are registered. A request sampled at a rising edge shows its effect on the outputs right after that edge. `msr_load` and `redirect_valid` are one-cycle pulses. `msr_value` and `redirect_pc` keep their last value between pulses. The core must write `msr_value` into its state register whenever `msr_load` pulses. A machine check that arrives while machine checks are disabled does not produce an interrupt. It freezes the unit in a checkstop state, which only reset clears.

Bit numbers below use big-endian numbering of a 32-bit word: bit 0 is the most significant bit, so big-endian bit n is vector index [31-n]. The state word fields used are: EE at bit 16, PR at 17, ME at 19, IP at 25, IR at 26, DR at 27 and RI at 30.

Top module: `intr_entry_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `msr_load`, `redirect_valid` and `checkstop` are 0. `msr_value` is 0x00000040 (IP set). `redirect_pc`, `srr0`, `srr1`, `dar` and `dsisr` are 0.
- R2: An interrupt taken at a rising edge raises `redirect_valid` for one cycle after that edge. `redirect_pc` then holds the vector offset for the source: system reset 0x100, machine check 0x200, data storage 0x300, instruction storage 0x400, external 0x500, decrementer 0x900, system call 0xC00. Its low 8 bits are always zero.
- R3: When `msr_in` bit IP (25) is 1, the vector is 0xFFFFF000 ORed with the offset. When IP is 0, the vector is the offset alone.
- R4: Only one interrupt is taken per edge. When several are enabled, the winner is, from highest to lowest: system reset, machine check, instruction storage, data storage, system call, external, decrementer. The losers have no effect.
- R5: External and decrementer requests are ignored while `msr_in` bit EE (16) is 0. System reset and machine check are never masked.
- R6: On entry, `srr1` takes `msr_in` bits 0, 5–9 and 16–31 in place. Bits 1–4 and 10–15 hold the cause, which is zero for every source except instruction storage.
- R7: For an instruction-storage interrupt, the `srr1` cause bits come from `isi_cause`. Bit 1 is `isi_cause[0]` (hashed translation miss). Bit 3 is `isi_cause[1]` (direct-store segment). Bit 4 is `isi_cause[2]` (protection). Bit 10 is `isi_cause[3]` (segment table miss).
- R8: On entry, `srr0` takes `cur_pc` for machine check, instruction storage and data storage. It takes `next_pc` for system reset, system call, external and decrementer.
- R9: On entry, `msr_load` pulses together with `redirect_valid`. `msr_value` is `msr_in` with IR (26), DR (27) and PR (17) cleared, and all other bits unchanged except RI (30). RI is `ctx_valid` for system reset and machine check, and 1 for every other source.
- R10: A data-storage interrupt loads `dar` from `dsi_addr` and `dsisr` from `dsi_status`. No other event changes `dar` or `dsisr`.
- R11: With no interrupt taken, an `rfi_req` at an edge pulses `msr_load` and `redirect_valid` after that edge, with `msr_value` = `srr1` and `redirect_pc` = `srr0`. `srr0` and `srr1` are left unchanged. If an interrupt is taken at the same edge, the interrupt wins and the `rfi_req` is dropped.
- R12: A machine check that wins while `msr_in` bit ME (19) is 0 sets `checkstop`. From then until reset, no request and no `rfi_req` pulses `redirect_valid` or `msr_load` or changes any register output. With ME at 1, a machine check is an ordinary interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sreset_req | input | 1 | System reset interrupt request |
| mchk_req | input | 1 | Machine check request |
| ext_req | input | 1 | External interrupt request |
| dec_req | input | 1 | Decrementer exception request |
| sc_req | input | 1 | System call instruction executed |
| isi_req | input | 1 | Instruction-storage fault |
| isi_cause | input | 4 | Instruction fault cause flags, see R7 |
| dsi_req | input | 1 | Data-storage fault |
| dsi_addr | input | 32 | Failing data address |
| dsi_status | input | DSISR_W | Data fault type code |
| ctx_valid | input | 1 | Context is recoverable for reset and machine check |
| rfi_req | input | 1 | Return-from-interrupt strobe |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next instruction |
| msr_in | input | 32 | Current machine state word |
| msr_load | output | 1 | Pulse: core loads msr_value |
| msr_value | output | 32 | New machine state word |
| redirect_valid | output | 1 | Pulse: fetch from redirect_pc |
| redirect_pc | output | 32 | New fetch address |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved state and cause |
| dar | output | 32 | Captured data fault address |
| dsisr | output | DSISR_W | Captured data fault type |
| checkstop | output | 1 | Unit is in checkstop |

## Verification
The hardest state to reach from the ports is checkstop followed by traffic. A machine check must win arbitration while ME is 0, and after that every request, including `rfi_req` and fully enabled externals, has to be shown to do nothing until reset. The bench sets this up directly by clearing ME in the state word it drives. It then floods the unit with every request kind. Random runs give ME a small chance of being 0 and reset the unit each time checkstop appears, so both sides of reset get exercised many times. The order of the two save/restore registers matters too. An `rfi_req` right after an entry must see the values just stored, and the bench reaches that case with back-to-back directed steps.

// File: rtl/intr_entry_pkg.sv
package intr_entry_pkg;

   localparam int XLEN = 32;

   // big-endian bit n of a 32-bit word sits at vector index 31-n
   function automatic int be2le(input int n);
      return XLEN - 1 - n;
   endfunction

   localparam int B_EE = 31 - 16;
   localparam int B_PR = 31 - 17;
   localparam int B_ME = 31 - 19;
   localparam int B_IP = 31 - 25;
   localparam int B_IR = 31 - 26;
   localparam int B_DR = 31 - 27;
   localparam int B_RI = 31 - 30;

   // source indices, index order is priority order (0 highest)
   localparam int NSRC    = 7;
   localparam int S_SRST  = 0;
   localparam int S_MCHK  = 1;
   localparam int S_ISI   = 2;
   localparam int S_DSI   = 3;
   localparam int S_SC    = 4;
   localparam int S_EXT   = 5;
   localparam int S_DEC   = 6;

   localparam int ISI_CW  = 4;

   // state bits that survive into the second save register
   function automatic logic [XLEN-1:0] keep_mask();
      logic [XLEN-1:0] m;
      m = '0;
      for (int n = 0; n < XLEN; n++) begin
         if (n == 0 || (n >= 5 && n <= 9) || n >= 16) m[be2le(n)] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [11:0] src_offset(input int s);
      case (s)
         S_SRST:  return 12'h100;
         S_MCHK:  return 12'h200;
         S_DSI:   return 12'h300;
         S_ISI:   return 12'h400;
         S_EXT:   return 12'h500;
         S_DEC:   return 12'h900;
         S_SC:    return 12'hC00;
         default: return 12'h000;
      endcase
   endfunction

endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_slot
         assign blocked[i+1] = blocked[i] | req[i];
         assign grant[i]     = req[i] & ~blocked[i];
      end
   endgenerate

   assign any = blocked[N];
endmodule

// File: rtl/intr_vec_form.sv
module intr_vec_form
   import intr_entry_pkg::*;
#(
   parameter bit              HAS_HIGH_PREFIX = 1'b1,
   parameter logic [XLEN-1:0] HIGH_PREFIX     = 32'hFFFF_F000
) (
   input  logic [NSRC-1:0] grant,
   input  logic            ip_bit,
   output logic [XLEN-1:0] vec
);
   logic [11:0]     offs;
   logic [XLEN-1:0] base;

   always_comb begin
      offs = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (grant[i]) offs = offs | src_offset(i);
      end
   end

   generate
      if (HIGH_PREFIX[11:0] != 12'h000) begin : g_bad_prefix
         $error("HIGH_PREFIX must leave the low 12 bits clear");
      end
      if (HAS_HIGH_PREFIX) begin : g_dual
         assign base = ip_bit ? HIGH_PREFIX : '0;
      end else begin : g_low_only
         logic unused_ip;
         assign unused_ip = ip_bit;
         assign base      = '0;
      end
   endgenerate

   assign vec = base | {{(XLEN-12){1'b0}}, offs};
endmodule

// File: rtl/intr_ctx_form.sv
module intr_ctx_form
   import intr_entry_pkg::*;
(
   input  logic [NSRC-1:0]   grant,
   input  logic [XLEN-1:0]   msr_in,
   input  logic [ISI_CW-1:0] isi_cause,
   input  logic              ctx_valid,
   input  logic [XLEN-1:0]   cur_pc,
   input  logic [XLEN-1:0]   next_pc,
   output logic [XLEN-1:0]   srr0_nxt,
   output logic [XLEN-1:0]   srr1_nxt,
   output logic [XLEN-1:0]   msr_nxt
);
   localparam logic [XLEN-1:0] KEEP = keep_mask();

   logic [XLEN-1:0] cause;
   logic            async_src;
   logic            at_fault;

   assign async_src = grant[S_SRST] | grant[S_MCHK];
   assign at_fault  = grant[S_MCHK] | grant[S_ISI] | grant[S_DSI];

   always_comb begin
      cause = '0;
      if (grant[S_ISI]) begin
         cause[be2le(1)]  = isi_cause[0];
         cause[be2le(3)]  = isi_cause[1];
         cause[be2le(4)]  = isi_cause[2];
         cause[be2le(10)] = isi_cause[3];
      end
   end

   assign srr1_nxt = (msr_in & KEEP) | (cause & ~KEEP);
   assign srr0_nxt = at_fault ? cur_pc : next_pc;

   always_comb begin
      msr_nxt       = msr_in;
      msr_nxt[B_IR] = 1'b0;
      msr_nxt[B_DR] = 1'b0;
      msr_nxt[B_PR] = 1'b0;
      msr_nxt[B_RI] = async_src ? ctx_valid : 1'b1;
   end
endmodule

// File: rtl/intr_entry_unit.sv
module intr_entry_unit
   import intr_entry_pkg::*;
#(
   parameter int              DSISR_W         = 32,
   parameter bit              HAS_HIGH_PREFIX = 1'b1,
   parameter logic [31:0]     HIGH_PREFIX     = 32'hFFFF_F000,
   parameter logic [31:0]     MSR_RESET       = 32'h0000_0040
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sreset_req,
   input  logic               mchk_req,
   input  logic               ext_req,
   input  logic               dec_req,
   input  logic               sc_req,
   input  logic               isi_req,
   input  logic [3:0]         isi_cause,
   input  logic               dsi_req,
   input  logic [31:0]        dsi_addr,
   input  logic [DSISR_W-1:0] dsi_status,
   input  logic               ctx_valid,
   input  logic               rfi_req,
   input  logic [31:0]        cur_pc,
   input  logic [31:0]        next_pc,
   input  logic [31:0]        msr_in,
   output logic               msr_load,
   output logic [31:0]        msr_value,
   output logic               redirect_valid,
   output logic [31:0]        redirect_pc,
   output logic [31:0]        srr0,
   output logic [31:0]        srr1,
   output logic [31:0]        dar,
   output logic [DSISR_W-1:0] dsisr,
   output logic               checkstop
);
   generate
      if (DSISR_W < 1 || DSISR_W > 32) begin : g_bad_w
         $error("DSISR_W must lie in 1..32");
      end
   endgenerate

   logic [NSRC-1:0] req_vec;
   logic [NSRC-1:0] grant;
   logic            take;
   logic [31:0]     vec;
   logic [31:0]     srr0_nxt;
   logic [31:0]     srr1_nxt;
   logic [31:0]     msr_nxt;
   logic            halt_now;

   always_comb begin
      req_vec         = '0;
      req_vec[S_SRST] = sreset_req;
      req_vec[S_MCHK] = mchk_req;
      req_vec[S_ISI]  = isi_req;
      req_vec[S_DSI]  = dsi_req;
      req_vec[S_SC]   = sc_req;
      req_vec[S_EXT]  = ext_req & msr_in[B_EE];
      req_vec[S_DEC]  = dec_req & msr_in[B_EE];
   end

   intr_prio_pick #(.N(NSRC)) u_pick (
      .req   (req_vec),
      .grant (grant),
      .any   (take)
   );

   intr_vec_form #(
      .HAS_HIGH_PREFIX (HAS_HIGH_PREFIX),
      .HIGH_PREFIX     (HIGH_PREFIX)
   ) u_vec (
      .grant  (grant),
      .ip_bit (msr_in[B_IP]),
      .vec    (vec)
   );

   intr_ctx_form u_ctx (
      .grant     (grant),
      .msr_in    (msr_in),
      .isi_cause (isi_cause),
      .ctx_valid (ctx_valid),
      .cur_pc    (cur_pc),
      .next_pc   (next_pc),
      .srr0_nxt  (srr0_nxt),
      .srr1_nxt  (srr1_nxt),
      .msr_nxt   (msr_nxt)
   );

   assign halt_now = grant[S_MCHK] & ~msr_in[B_ME];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msr_load       <= 1'b0;
         msr_value      <= MSR_RESET;
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
         srr0           <= '0;
         srr1           <= '0;
         dar            <= '0;
         dsisr          <= '0;
         checkstop      <= 1'b0;
      end else begin
         msr_load       <= 1'b0;
         redirect_valid <= 1'b0;
         if (!checkstop) begin
            if (take) begin
               if (halt_now) begin
                  checkstop <= 1'b1;
               end else begin
                  srr0           <= srr0_nxt;
                  srr1           <= srr1_nxt;
                  msr_value      <= msr_nxt;
                  msr_load       <= 1'b1;
                  redirect_valid <= 1'b1;
                  redirect_pc    <= vec;
                  if (grant[S_DSI]) begin
                     dar   <= dsi_addr;
                     dsisr <= dsi_status;
                  end
               end
            end else if (rfi_req) begin
               msr_value      <= srr1;
               msr_load       <= 1'b1;
               redirect_pc    <= srr0;
               redirect_valid <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/intr_entry_unit_chk.sv
module intr_entry_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sreset_req,
   input logic        mchk_req,
   input logic        ext_req,
   input logic        dec_req,
   input logic        sc_req,
   input logic        isi_req,
   input logic        dsi_req,
   input logic        rfi_req,
   input logic [31:0] msr_in,
   input logic        msr_load,
   input logic [31:0] msr_value,
   input logic        redirect_valid,
   input logic [31:0] redirect_pc,
   input logic        checkstop
);
   logic others_idle;
   assign others_idle = !(sreset_req || mchk_req || isi_req || dsi_req || sc_req || rfi_req);

   assert_checkstop_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |=> checkstop);

   assert_checkstop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |-> (!redirect_valid && !msr_load));

   assert_reset_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_valid && $past(sreset_req)) |-> (redirect_pc[11:0] == 12'h100));

   assert_supervisor_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_valid && $past(sreset_req)) |-> (!msr_value[14] && !msr_value[5] && !msr_value[4]));

   assert_ee_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past((ext_req || dec_req) && !msr_in[15] && others_idle) |-> !redirect_valid);

   assert_entry_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (redirect_valid && !$past(rfi_req)) |-> (redirect_pc[7:0] == 8'h00));

   assert_load_with_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_valid |-> msr_load);
endmodule

bind intr_entry_unit intr_entry_unit_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sreset_req     (sreset_req),
   .mchk_req       (mchk_req),
   .ext_req        (ext_req),
   .dec_req        (dec_req),
   .sc_req         (sc_req),
   .isi_req        (isi_req),
   .dsi_req        (dsi_req),
   .rfi_req        (rfi_req),
   .msr_in         (msr_in),
   .msr_load       (msr_load),
   .msr_value      (msr_value),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .checkstop      (checkstop)
);

// File: tb/intr_entry_unit_test.sv
module intr_entry_unit_test;
   localparam int PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic sreset_req, mchk_req, ext_req, dec_req, sc_req, isi_req, dsi_req, rfi_req, ctx_valid;
   logic [3:0]  isi_cause;
   logic [31:0] dsi_addr, dsi_status, cur_pc, next_pc, msr_in;
   logic        msr_load, redirect_valid, checkstop;
   logic [31:0] msr_value, redirect_pc, srr0, srr1, dar, dsisr;

   int checks = 0;
   int fails  = 0;

   // model state
   logic        m_ld, m_rv, m_cs;
   logic [31:0] m_mv, m_pc, m_s0, m_s1, m_dar, m_dsisr;

   always #(PERIOD/2) clk = ~clk;

   intr_entry_unit uut (
      .clk(clk), .rst_n(rst_n), .sreset_req(sreset_req), .mchk_req(mchk_req),
      .ext_req(ext_req), .dec_req(dec_req), .sc_req(sc_req), .isi_req(isi_req),
      .isi_cause(isi_cause), .dsi_req(dsi_req), .dsi_addr(dsi_addr), .dsi_status(dsi_status),
      .ctx_valid(ctx_valid), .rfi_req(rfi_req), .cur_pc(cur_pc), .next_pc(next_pc),
      .msr_in(msr_in), .msr_load(msr_load), .msr_value(msr_value),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .srr0(srr0), .srr1(srr1),
      .dar(dar), .dsisr(dsisr), .checkstop(checkstop)
   );

   function automatic logic bb(input logic [31:0] v, input int n);
      return v[31-n];
   endfunction

   function automatic logic [31:0] offset_of(input int s);
      case (s)
         0: return 32'h100; 1: return 32'h200; 2: return 32'h400; 3: return 32'h300;
         4: return 32'hC00; 5: return 32'h500; default: return 32'h900;
      endcase
   endfunction

   task automatic clear_inputs();
      sreset_req = 0; mchk_req = 0; ext_req = 0; dec_req = 0; sc_req = 0;
      isi_req = 0; dsi_req = 0; rfi_req = 0; ctx_valid = 0; isi_cause = '0;
      dsi_addr = '0; dsi_status = '0; cur_pc = '0; next_pc = '0; msr_in = 32'h40;
   endtask

   task automatic model_reset();
      m_ld = 0; m_rv = 0; m_cs = 0; m_mv = 32'h40; m_pc = '0;
      m_s0 = '0; m_s1 = '0; m_dar = '0; m_dsisr = '0;
   endtask

   // expected outputs after the next edge, from the requirements
   task automatic model_edge();
      int win;
      logic [31:0] s1, m;
      m_ld = 0; m_rv = 0;
      if (m_cs) return;
      win = -1;
      if (sreset_req) win = 0;
      else if (mchk_req) win = 1;
      else if (isi_req) win = 2;
      else if (dsi_req) win = 3;
      else if (sc_req) win = 4;
      else if (ext_req && bb(msr_in, 16)) win = 5;
      else if (dec_req && bb(msr_in, 16)) win = 6;
      if (win == 1 && !bb(msr_in, 19)) begin
         m_cs = 1;
      end else if (win >= 0) begin
         s1 = '0;
         for (int n = 0; n < 32; n++)
            if (n == 0 || (n >= 5 && n <= 9) || n >= 16) s1[31-n] = msr_in[31-n];
         if (win == 2) begin
            s1[31-1] = isi_cause[0]; s1[31-3] = isi_cause[1];
            s1[31-4] = isi_cause[2]; s1[31-10] = isi_cause[3];
         end
         m = msr_in;
         m[31-26] = 0; m[31-27] = 0; m[31-17] = 0;
         m[31-30] = (win <= 1) ? ctx_valid : 1'b1;
         m_s1 = s1;
         m_s0 = (win >= 1 && win <= 3) ? cur_pc : next_pc;
         m_mv = m; m_ld = 1; m_rv = 1;
         m_pc = (bb(msr_in, 25) ? 32'hFFFFF000 : 32'h0) | offset_of(win);
         if (win == 3) begin m_dar = dsi_addr; m_dsisr = dsi_status; end
      end else if (rfi_req) begin
         m_mv = m_s1; m_pc = m_s0; m_ld = 1; m_rv = 1;
      end
   endtask

   task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "msr_load", {31'b0, msr_load}, {31'b0, m_ld});
      chk(tag, "redirect_valid", {31'b0, redirect_valid}, {31'b0, m_rv});
      chk(tag, "checkstop", {31'b0, checkstop}, {31'b0, m_cs});
      chk(tag, "msr_value", msr_value, m_mv);
      chk(tag, "redirect_pc", redirect_pc, m_pc);
      chk(tag, "srr0", srr0, m_s0);
      chk(tag, "srr1", srr1, m_s1);
      chk(tag, "dar", dar, m_dar);
      chk(tag, "dsisr", dsisr, m_dsisr);
   endtask

   // inputs are set at a falling edge; one rising edge later, check at the next falling edge
   task automatic step(input string tag);
      model_edge();
      @(negedge clk);
      check_all(tag);
      clear_inputs();
   endtask

   task automatic do_reset();
      rst_n = 0;
      clear_inputs();
      repeat (2) @(negedge clk);
      model_reset();
      check_all("R1 in reset");
      rst_n = 1;
      @(negedge clk);
      check_all("R1 after release");
   endtask

   initial begin
      #(PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      clear_inputs();
      model_reset();
      @(negedge clk);
      do_reset();

      // R2 R3 R8 R9: system reset, high prefix
      sreset_req = 1; msr_in = 32'h0000_F073 | 32'h40; ctx_valid = 1;
      cur_pc = 32'h1000; next_pc = 32'h1004; step("R2 R3 R8 R9 sreset");
      // R9 R8: machine check ME=1, unrecoverable
      mchk_req = 1; msr_in = 32'h0000_10F0; ctx_valid = 0; cur_pc = 32'h2220; next_pc = 32'h2224;
      step("R9 R8 mchk");
      // R5: external masked then taken, low prefix (R3)
      ext_req = 1; msr_in = 32'h0000_0000; step("R5 ext masked");
      dec_req = 1; msr_in = 32'h0000_0000; step("R5 dec masked");
      ext_req = 1; msr_in = 32'h0000_8000; next_pc = 32'h300; step("R5 R3 ext taken");
      dec_req = 1; msr_in = 32'h0000_8040; next_pc = 32'h500; step("R5 R2 dec taken");
      // R6 R7: instruction fault with all cause flags and full state
      isi_req = 1; isi_cause = 4'hF; msr_in = 32'hFFFF_FFFF; cur_pc = 32'h7770;
      step("R6 R7 isi all");
      isi_req = 1; isi_cause = 4'b0101; msr_in = 32'h7838_0000; cur_pc = 32'h7774;
      step("R7 isi partial");
      // R10: data fault captures, later system call leaves it
      dsi_req = 1; dsi_addr = 32'hDEAD_BEE0; dsi_status = 32'h4200_0000; cur_pc = 32'h88;
      msr_in = 32'h0000_4000; step("R10 dsi");
      sc_req = 1; dsi_addr = 32'h1; dsi_status = 32'h2; msr_in = 32'h0000_C030;
      next_pc = 32'h4004; step("R10 R6 sc keeps dar");
      // R11: return right after entry
      rfi_req = 1; step("R11 rfi");
      rfi_req = 1; ext_req = 1; msr_in = 32'h0000_8000; next_pc = 32'h9990;
      step("R11 ext beats rfi");
      // R4: everything pending, peel off one by one
      for (int k = 0; k < 7; k++) begin
         msr_in = 32'h0000_9040; ctx_valid = 1; cur_pc = 32'h100 + k; next_pc = 32'h200 + k;
         sreset_req = (k <= 0); mchk_req = (k <= 1); isi_req = (k <= 2); dsi_req = (k <= 3);
         sc_req = (k <= 4); ext_req = (k <= 5); dec_req = 1; isi_cause = 4'hA;
         dsi_addr = 32'hA000 + k; dsi_status = k;
         step("R4 priority");
      end
      // R12: checkstop and quiescence
      mchk_req = 1; msr_in = 32'h0000_8000; step("R12 enter checkstop");
      ext_req = 1; dec_req = 1; sc_req = 1; isi_req = 1; dsi_req = 1; rfi_req = 1;
      msr_in = 32'h0000_9040; dsi_addr = 32'h55; step("R12 frozen");
      sreset_req = 1; step("R12 frozen sreset");
      do_reset();

      // random phase
      for (int it = 0; it < 3000; it++) begin
         sreset_req = ($urandom % 32) == 0;
         mchk_req   = ($urandom % 16) == 0;
         isi_req    = ($urandom % 8) == 0;
         dsi_req    = ($urandom % 8) == 0;
         sc_req     = ($urandom % 8) == 0;
         ext_req    = ($urandom % 4) == 0;
         dec_req    = ($urandom % 4) == 0;
         rfi_req    = ($urandom % 4) == 0;
         ctx_valid  = $urandom % 2;
         isi_cause  = $urandom;
         dsi_addr   = $urandom; dsi_status = $urandom;
         cur_pc     = $urandom & 32'hFFFF_FFFC; next_pc = cur_pc + 4;
         msr_in     = $urandom;
         msr_in[31-19] = ($urandom % 8) != 0;
         step("R4 R6 R8 R11 random");
         if (checkstop) do_reset();
      end

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule